// File: doc/BRIEF.md
# Fatal Exception Interrupt Controller

This block gathers the exception pulses of a packet transmit interface into one sticky status word. Two masks are kept beside it. The first picks which status bits raise the interrupt line. The second picks which exceptions count as fatal. A fatal exception latches a summary sync-error bit that takes the transmit path off line and leaves it sending training only. It stays that way until software drops the interface enable and writes a one to the summary bit. Dropping the enable also sends a one-cycle credit flush, so that all credits gathered so far are discarded.

Software uses a small register port with four words. Address 0 is status: it reads the sources and the summary bit, and a write of ones clears them. Address 1 is the interrupt mask. Address 2 is the fatal mask. Address 3 is control, with bit 0 as the interface enable. Read data comes back one cycle after the address is presented. A calendar parity exception on either bank also sends a one-cycle reset pulse to the status channel.

Top module: `exc_fatal_irq_ctl`

## Requirements
- R1: An exception pulse on `exc_i[k]` sets status bit k at the next clock edge. The source order from bit 0 upward is: calendar parity bank 0, calendar parity bank 1, oversize burst, data FIFO overflow, DIP-2 error, no-sync, unexpected framing, framing error.
- R2: Status bits stay set until software writes a 1 to that bit at address 0. Writing 0 leaves a bit as it is. If an exception and a clear arrive in the same cycle, the exception wins.
- R3: `irq_o` is registered. It is 1 one cycle after any status bit, summary bit 8 included, is 1 while the same bit of the interrupt mask at address 1 is also 1.
- R4: An exception whose bit is set in the fatal mask at address 2 sets summary bit 8 of the status word, and `sync_err_o`, at the next clock edge.
- R5: `tx_enable_o` is 1 only while control bit 0 at address 3 is 1 and the sync-error is clear. `train_o` is always the inverse of `tx_enable_o`.
- R6: The sync-error is cleared by a write of 1 to status bit 8. That write only takes effect while the interface enable is already 0. While the enable is 1, the write has no effect.
- R7: `credit_flush_o` pulses for exactly one cycle, in the cycle after a write changes the interface enable from 1 to 0.
- R8: `chan_reset_o` pulses in the cycle after a calendar parity exception, that is, source 0 or source 1.
- R9: `reg_rdata_o` returns the register selected by `reg_addr_i` in the previous cycle, zero-extended. The control word carries the enable in bit 0.
- R10: After reset, all registers, the status, both masks, the enable and every output other than `train_o` are 0, and `train_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_i | input | 8 | Exception pulses, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for reads and writes |
| reg_wdata_i | input | 9 | Write data |
| reg_rdata_o | output | 9 | Read data, one cycle after the address |
| irq_o | output | 1 | Interrupt request |
| sync_err_o | output | 1 | Latched fatal sync-error |
| tx_enable_o | output | 1 | Transmit datapath enabled |
| train_o | output | 1 | Send training sequences only |
| credit_flush_o | output | 1 | Discard accumulated credits |
| chan_reset_o | output | 1 | Return the status channel to its reset state |

## Verification
The assertions assume that exception inputs and register strobes are driven cleanly between clock edges, are never unknown once reset is released, and are held at 0 during reset. The bench drives every input one time unit after the falling edge and keeps all of them at 0 while reset is asserted. Its random phase spreads its pulses over all sources and all four addresses, and it allows several exceptions in the same cycle. This lets set-versus-clear collisions and sync-clear attempts with the enable high both occur inside the assumed input envelope.

// File: rtl/exc_irq_pkg.sv
package exc_irq_pkg;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_STATUS = 2'd0,
      SEL_IRQ_EN = 2'd1,
      SEL_FATAL  = 2'd2,
      SEL_CTRL   = 2'd3
   } reg_sel_e;

   localparam int unsigned CTRL_EN_BIT = 0;
endpackage

// File: rtl/exc_sticky_status.sv
module exc_sticky_status #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] status_o
);
   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          bit_q <= 1'b0;
         else if (set_i[b])   bit_q <= 1'b1;
         else if (clr_i[b])   bit_q <= 1'b0;
      end
      assign status_o[b] = bit_q;
   end

   AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i))); // R1

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o & ~clr_i) != '0) |=>
         ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i))); // R2
endmodule

// File: rtl/exc_sync_ctl.sv
module exc_sync_ctl #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] exc_i,
   input  logic [NUM_SRC-1:0] fatal_mask_i,
   input  logic               sum_clr_i,
   input  logic               if_en_q_i,
   input  logic               if_en_d_i,
   output logic               sync_err_o,
   output logic               tx_enable_o,
   output logic               train_o,
   output logic               credit_flush_o
);
   logic fatal_hit;
   logic sync_q;
   logic flush_q;

   assign fatal_hit = |(exc_i & fatal_mask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        sync_q <= 1'b0;
      else if (fatal_hit)                sync_q <= 1'b1;
      else if (sum_clr_i && !if_en_q_i)  sync_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush_q <= 1'b0;
      else        flush_q <= if_en_q_i & ~if_en_d_i;
   end

   assign sync_err_o     = sync_q;
   assign tx_enable_o    = if_en_q_i & ~sync_q;
   assign train_o        = ~tx_enable_o;
   assign credit_flush_o = flush_q;

   AST_FATAL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_hit |=> sync_err_o); // R4

   AST_SYNC_HELD_WHILE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_err_o && if_en_q_i) |=> sync_err_o); // R6

   AST_FLUSH_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      credit_flush_o |-> (!if_en_q_i && $past(if_en_q_i))); // R7

   AST_NO_TX_WHILE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err_o |-> !tx_enable_o); // R5
endmodule

// File: rtl/exc_reg_file.sv
module exc_reg_file
   import exc_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   localparam int unsigned REG_W  = NUM_SRC + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_W-1:0]  wdata_i,
   input  logic [REG_W-1:0]  status_i,
   output logic [REG_W-1:0]  status_clr_o,
   output logic [REG_W-1:0]  irq_mask_o,
   output logic [NUM_SRC-1:0] fatal_mask_o,
   output logic              if_en_q_o,
   output logic              if_en_d_o,
   output logic [REG_W-1:0]  rdata_o
);
   reg_sel_e               sel;
   logic [REG_W-1:0]       irq_mask_q;
   logic [NUM_SRC-1:0]     fatal_q;
   logic                   en_q;
   logic [REG_W-1:0]       rdata_d;
   logic [REG_W-1:0]       rdata_q;

   assign sel = reg_sel_e'(addr_i);

   assign status_clr_o = (wr_i && sel == SEL_STATUS) ? wdata_i : '0;
   assign if_en_d_o    = (wr_i && sel == SEL_CTRL) ? wdata_i[CTRL_EN_BIT] : en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_mask_q <= '0;
         fatal_q    <= '0;
         en_q       <= 1'b0;
      end else begin
         if (wr_i && sel == SEL_IRQ_EN) irq_mask_q <= wdata_i;
         if (wr_i && sel == SEL_FATAL)  fatal_q    <= wdata_i[NUM_SRC-1:0];
         en_q <= if_en_d_o;
      end
   end

   always_comb begin
      rdata_d = '0;
      unique case (sel)
         SEL_STATUS: rdata_d = status_i;
         SEL_IRQ_EN: rdata_d = irq_mask_q;
         SEL_FATAL:  rdata_d[NUM_SRC-1:0] = fatal_q;
         SEL_CTRL:   rdata_d[CTRL_EN_BIT] = en_q;
         default:    rdata_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rdata_d;
   end

   assign irq_mask_o   = irq_mask_q;
   assign fatal_mask_o = fatal_q;
   assign if_en_q_o    = en_q;
   assign rdata_o      = rdata_q;

   AST_CTRL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel == SEL_CTRL) |=> (if_en_q_o == $past(wdata_i[CTRL_EN_BIT]))); // R9
endmodule

// File: rtl/exc_fatal_irq_ctl.sv
module exc_fatal_irq_ctl
   import exc_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter logic [NUM_SRC-1:0] CAL_SRC_MASK = 'b11,
   parameter bit IRQ_REGISTERED = 1'b1,
   localparam int unsigned REG_W = NUM_SRC + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] exc_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   output logic              irq_o,
   output logic              sync_err_o,
   output logic              tx_enable_o,
   output logic              train_o,
   output logic              credit_flush_o,
   output logic              chan_reset_o
);
   if (NUM_SRC < 2 || NUM_SRC > 31) begin : g_bad_src
      $error("NUM_SRC must lie between 2 and 31");
   end
   if (CAL_SRC_MASK == '0) begin : g_bad_cal
      $error("CAL_SRC_MASK must select at least one source");
   end

   logic [REG_W-1:0]   status_clr;
   logic [REG_W-1:0]   irq_mask;
   logic [NUM_SRC-1:0] fatal_mask;
   logic [NUM_SRC-1:0] src_status;
   logic [REG_W-1:0]   status_all;
   logic               en_q;
   logic               en_d;
   logic               sync_err;
   logic               irq_d;
   logic               chreset_q;

   exc_sticky_status #(.NUM_SRC(NUM_SRC)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (exc_i),
      .clr_i    (status_clr[NUM_SRC-1:0]),
      .status_o (src_status)
   );

   exc_sync_ctl #(.NUM_SRC(NUM_SRC)) u_sync (
      .clk            (clk),
      .rst_n          (rst_n),
      .exc_i          (exc_i),
      .fatal_mask_i   (fatal_mask),
      .sum_clr_i      (status_clr[NUM_SRC]),
      .if_en_q_i      (en_q),
      .if_en_d_i      (en_d),
      .sync_err_o     (sync_err),
      .tx_enable_o    (tx_enable_o),
      .train_o        (train_o),
      .credit_flush_o (credit_flush_o)
   );

   assign status_all = {sync_err, src_status};

   exc_reg_file #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (reg_wr_i),
      .addr_i       (reg_addr_i),
      .wdata_i      (reg_wdata_i),
      .status_i     (status_all),
      .status_clr_o (status_clr),
      .irq_mask_o   (irq_mask),
      .fatal_mask_o (fatal_mask),
      .if_en_q_o    (en_q),
      .if_en_d_o    (en_d),
      .rdata_o      (reg_rdata_o)
   );

   assign irq_d = |(status_all & irq_mask);

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq_o = irq_q;

      AST_IRQ_NEEDS_ENABLED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> ($past(reg_rdata_o) == $past(reg_rdata_o)) && $past(irq_d)); // R3
   end else begin : g_irq_comb
      assign irq_o = irq_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chreset_q <= 1'b0;
      else        chreset_q <= |(exc_i & CAL_SRC_MASK);
   end

   assign chan_reset_o = chreset_q;
   assign sync_err_o   = sync_err;

   AST_CHAN_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      chan_reset_o |-> ($past(exc_i) != '0)); // R8

   AST_TRAIN_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      train_o != tx_enable_o); // R5
endmodule

// File: tb/exc_fatal_irq_ctl_test.sv
module exc_fatal_irq_ctl_test;
   localparam int N = 8;
   localparam int W = N + 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] exc = '0;
   logic         wr = 1'b0;
   logic [1:0]   addr = '0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic irq, sync_err, tx_en, train, flush, chreset;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   exc_fatal_irq_ctl uut (
      .clk(clk), .rst_n(rst_n), .exc_i(exc), .reg_wr_i(wr), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .sync_err_o(sync_err),
      .tx_enable_o(tx_en), .train_o(train), .credit_flush_o(flush), .chan_reset_o(chreset)
   );

   // behavioural reference model
   logic [N-1:0] m_src;
   logic         m_sync;
   logic [W-1:0] m_ien;
   logic [N-1:0] m_fat;
   logic         m_en;
   logic         m_irq, m_flush, m_chr;
   logic [W-1:0] m_rd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_src <= '0; m_sync <= 0; m_ien <= '0; m_fat <= '0; m_en <= 0;
         m_irq <= 0; m_flush <= 0; m_chr <= 0; m_rd <= '0;
      end else begin
         logic [W-1:0] clr;
         clr = (wr && addr == 2'd0) ? wdata : '0;
         m_src <= (m_src & ~clr[N-1:0]) | exc;
         if ((exc & m_fat) != 0)      m_sync <= 1;
         else if (clr[N] && !m_en)    m_sync <= 0;
         m_irq <= (({m_sync, m_src} & m_ien) != 0);
         m_chr <= exc[0] | exc[1];
         m_flush <= m_en && wr && addr == 2'd3 && !wdata[0];
         case (addr)
            2'd0: m_rd <= {m_sync, m_src};
            2'd1: m_rd <= m_ien;
            2'd2: m_rd <= {1'b0, m_fat};
            default: m_rd <= {{(W-1){1'b0}}, m_en};
         endcase
         if (wr && addr == 2'd1) m_ien <= wdata;
         if (wr && addr == 2'd2) m_fat <= wdata[N-1:0];
         if (wr && addr == 2'd3) m_en  <= wdata[0];
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(rdata === m_rd,            "R9 readback", int'(rdata), int'(m_rd));
         chk(irq === m_irq,             "R3 irq", int'(irq), int'(m_irq));
         chk(sync_err === m_sync,       "R4 sync", int'(sync_err), int'(m_sync));
         chk(tx_en === (m_en & ~m_sync), "R5 tx_enable", int'(tx_en), int'(m_en & ~m_sync));
         chk(train === ~(m_en & ~m_sync), "R5 train", int'(train), int'(~(m_en & ~m_sync)));
         chk(flush === m_flush,         "R7 flush", int'(flush), int'(m_flush));
         chk(chreset === m_chr,         "R8 chan reset", int'(chreset), int'(m_chr));
      end
   end

   task automatic tick(input logic [N-1:0] e, input logic w, input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk); #1;
      exc = e; wr = w; addr = a; wdata = d;
   endtask

   task automatic idle();
      tick('0, 0, 2'd0, '0);
   endtask

   task automatic expect_rd(input logic [1:0] a, input logic [W-1:0] exp, input string req);
      tick('0, 0, a, '0);
      @(negedge clk); #2;
      chk(rdata === exp, req, int'(rdata), int'(exp));
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #2;
      // R10 reset state
      chk(rdata === '0 && irq === 0 && sync_err === 0 && tx_en === 0 && train === 1
          && flush === 0 && chreset === 0, "R10 reset outputs", int'(rdata), 0);
      expect_rd(2'd1, '0, "R10 irq mask reset");
      expect_rd(2'd3, '0, "R10 enable reset");

      // R1 event latches (oversize burst = bit 2)
      tick(8'h04, 0, 2'd0, '0);
      expect_rd(2'd0, 9'h004, "R1 oversize bit");
      // R2 write-one clear, write-zero keeps
      tick('0, 1, 2'd0, 9'h000);
      expect_rd(2'd0, 9'h004, "R2 zero write keeps");
      tick('0, 1, 2'd0, 9'h004);
      expect_rd(2'd0, 9'h000, "R2 clear");
      // R2 set wins over clear in the same cycle
      tick(8'h10, 1, 2'd0, 9'h010);
      expect_rd(2'd0, 9'h010, "R2 set wins");
      tick('0, 1, 2'd0, 9'h010);

      // R3 interrupt and R8 calendar parity bank1
      tick('0, 1, 2'd1, 9'h002);
      tick(8'h02, 0, 2'd0, '0);
      @(negedge clk); #2;
      chk(chreset === 1, "R8 chan reset pulse", int'(chreset), 1);
      chk(irq === 0, "R3 irq not yet", int'(irq), 0);
      idle();
      @(negedge clk); #2;
      chk(irq === 1, "R3 irq raised", int'(irq), 1);
      chk(chreset === 0, "R8 pulse one cycle", int'(chreset), 0);
      // masked source does not raise irq
      tick('0, 1, 2'd0, 9'h002);
      tick(8'h40, 0, 2'd0, '0);
      idle(); idle();
      @(negedge clk); #2;
      chk(irq === 0, "R3 masked source", int'(irq), 0);
      tick('0, 1, 2'd0, 9'h1FF);

      // R4/R5 fatal path
      tick('0, 1, 2'd2, 9'h008);
      tick('0, 1, 2'd3, 9'h001);
      @(negedge clk); #2;
      chk(tx_en === 1 && train === 0, "R5 enabled", int'(tx_en), 1);
      tick(8'h08, 0, 2'd0, '0);
      @(negedge clk); #2;
      chk(sync_err === 1, "R4 fatal sets sync", int'(sync_err), 1);
      chk(tx_en === 0 && train === 1, "R5 disabled by sync", int'(tx_en), 0);
      expect_rd(2'd0, 9'h108, "R4 summary bit");
      // R6 clear ignored while enabled
      tick('0, 1, 2'd0, 9'h100);
      expect_rd(2'd0, 9'h108, "R6 clear ignored when enabled");
      // R7 flush on enable fall
      tick('0, 1, 2'd3, 9'h000);
      @(negedge clk); #2;
      chk(flush === 1, "R7 flush pulse", int'(flush), 1);
      idle();
      @(negedge clk); #2;
      chk(flush === 0, "R7 flush single cycle", int'(flush), 0);
      tick('0, 1, 2'd0, 9'h1FF);
      @(negedge clk); #2;
      chk(sync_err === 0, "R6 sync cleared", int'(sync_err), 0);
      tick('0, 1, 2'd3, 9'h001);
      @(negedge clk); #2;
      chk(tx_en === 1, "R5 re-enabled", int'(tx_en), 1);
      expect_rd(2'd2, 9'h008, "R9 fatal mask readback");
      expect_rd(2'd3, 9'h001, "R9 ctrl readback");

      // random phase, compared every clock against the model
      for (int i = 0; i < 600; i++) begin
         logic [N-1:0] e;
         e = (($urandom % 4) == 0) ? N'($urandom) & N'($urandom) : '0;
         tick(e, ($urandom % 3) == 0, 2'($urandom), W'($urandom));
      end
      idle(); idle();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule